// File: doc/BRIEF.md
# Frame-Scheduled Sensor Command Sequencer

This block holds sensor register commands written by a host and releases them at frame boundaries. Each command is a 32-bit word, placed either in one of 16 absolute queues, chosen by frame number modulo 16, or through a relative address that names a frame offset from the current one. Offset zero selects a separate queue that is drained as soon as possible. Every queue is a FIFO of up to 8 words.

A per-page table sets how each command turns into bus bytes. The page is taken from the top byte of the command word. Each table entry gives the slave address, a read/write choice, the register address width for reads, and a byte count. The output is a valid/ready stream of tokens (start, byte, restart, stop) for a downstream bit-level two-wire engine. The bit-level engine and the capture of read data are not part of this block.

Top module: `frame_cmd_seq`

## Requirements
- R1: After reset `frame_o` is 0, `overflow_o` is 0 and `tok_valid_o` is 0.
- R2: Token types are encoded START=0, BYTE=1, RESTART=2, STOP=3. The command page is `cmd_data_i[24 +: PAGE_W]`. A table entry is {rd[13], two_byte[12], count[11:8], slave[7:0]}. A write command (rd=0) with count 3 emits START, then BYTE with the table slave address and bit 0 cleared, then BYTE for bits [23:16], [15:8] and [7:0] in that order, then STOP.
- R3: A write command with a count of 1 or 2 sends only that many of its lowest bytes, in descending order. The higher bytes are skipped.
- R4: A write command with a count above 3 sends its own three bytes, then pops further words from the same queue. All four bytes of each further word are payload, sent from the most significant down, until the count is used up. A last word that needs fewer than 4 bytes sends only its lower bytes.
- R5: A read command (rd=1) emits START, then BYTE {word[23:17],0}. Next comes BYTE word[15:8], only when two_byte=1, and then BYTE word[7:0]. It ends with RESTART, BYTE {word[23:17],1} and STOP.
- R6: An absolute queue is served only while `frame_o` equals its index.
- R7: Each `frame_sync_i` pulse increments `frame_o` by one modulo 16. Without a pulse, `frame_o` holds.
- R8: A relative write with offset 0 goes to the ASAP queue. Offset k from 1 to 14 goes to queue (frame_o + k) mod 16, using the frame value before any `frame_sync_i` in the same cycle. Offset 15 is ignored.
- R9: When a command ends, the ASAP queue is served before the queue of the current frame.
- R10: A write to a queue that already holds 8 words is dropped and sets `overflow_o`, which then stays set until reset.
- R11: While `tok_valid_o` is high and `tok_ready_i` is low, the token type and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_sync_i | input | 1 | Frame boundary pulse |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_rel_i | input | 1 | 1: slot field is a frame offset; 0: absolute frame |
| cmd_slot_i | input | FRAME_W | Absolute frame or relative offset |
| cmd_data_i | input | 32 | Command word |
| tbl_we_i | input | 1 | Page table write strobe |
| tbl_page_i | input | PAGE_W | Page table index |
| tbl_ent_i | input | 14 | Page table entry |
| tok_ready_i | input | 1 | Downstream accepts token |
| tok_valid_o | output | 1 | Token valid |
| tok_type_o | output | 2 | Token type |
| tok_data_o | output | 8 | Token byte |
| frame_o | output | FRAME_W | Current frame number |
| overflow_o | output | 1 | Sticky queue overflow flag |

## Verification
Two events can fall in the same clock edge: a host write and a frame sync. A relative write with offset 1, issued in the same cycle as a sync, must land in the queue that becomes current, and so drain without a second sync. An ASAP write paired with a sync, while the next frame's queue already holds a command, must come out first. Both cases are driven on one negedge and judged by the order of the tokens that follow.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
  typedef enum logic [1:0] {
    TOK_START   = 2'd0,
    TOK_BYTE    = 2'd1,
    TOK_RESTART = 2'd2,
    TOK_STOP    = 2'd3
  } tok_e;

  typedef struct packed {
    logic       rd;
    logic       two_byte;
    logic [3:0] cnt;
    logic [7:0] sa;
  } page_ent_t;

  localparam int ENT_W = $bits(page_ent_t);
endpackage

// File: rtl/fcs_fifo.sv
`timescale 1ns/1ps
module fcs_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= din_i;
        wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      end
      if (do_pop) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/fcs_page_table.sv
`timescale 1ns/1ps
module fcs_page_table import fcs_pkg::*; #(
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] waddr_i,
  input  page_ent_t         wdata_i,
  input  logic [PAGE_W-1:0] raddr_i,
  output page_ent_t         rdata_o
);
  localparam int NPAGE = 1 << PAGE_W;

  page_ent_t tbl_q [NPAGE];

  assign rdata_o = tbl_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPAGE; i++) tbl_q[i] <= '0;
    end else if (we_i) begin
      tbl_q[waddr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/fcs_engine.sv
`timescale 1ns/1ps
module fcs_engine import fcs_pkg::*; #(
  parameter int FW       = 4,
  parameter int QW       = 5,
  parameter int ASAP_IDX = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          asap_empty_i,
  input  logic [FW-1:0] frame_i,
  input  logic [31:0]   head_i,
  input  logic          src_empty_i,
  input  page_ent_t     ent_i,
  input  logic          tok_ready_i,
  output logic [QW-1:0] src_o,
  output logic          pop_o,
  output logic          tok_valid_o,
  output logic [1:0]    tok_type_o,
  output logic [7:0]    tok_data_o
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_SA, ST_PL, ST_FETCH, ST_RA, ST_RS, ST_SA2, ST_STOP
  } st_e;

  st_e       st_q;
  logic [31:0] w_q;
  page_ent_t ent_q;
  logic [1:0]  bi_q;
  logic [3:0]  rem_q;
  logic [QW-1:0] src_q;
  logic fire;
  logic [7:0] cur_byte;
  tok_e ttype;

  assign src_o = (st_q == ST_IDLE) ? (asap_empty_i ? QW'(frame_i) : QW'(ASAP_IDX)) : src_q;
  assign pop_o = ((st_q == ST_IDLE) || (st_q == ST_FETCH)) && !src_empty_i;
  assign cur_byte = w_q[{bi_q, 3'b000} +: 8];

  always_comb begin
    tok_valid_o = 1'b1;
    ttype       = TOK_BYTE;
    tok_data_o  = 8'h00;
    unique case (st_q)
      ST_START: ttype = TOK_START;
      ST_SA:    tok_data_o = ent_q.rd ? {w_q[23:17], 1'b0} : {ent_q.sa[7:1], 1'b0};
      ST_PL,
      ST_RA:    tok_data_o = cur_byte;
      ST_RS:    ttype = TOK_RESTART;
      ST_SA2:   tok_data_o = {w_q[23:17], 1'b1};
      ST_STOP:  ttype = TOK_STOP;
      default:  tok_valid_o = 1'b0;
    endcase
  end
  assign tok_type_o = ttype;
  assign fire = tok_valid_o && tok_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      w_q   <= '0;
      ent_q <= '0;
      bi_q  <= '0;
      rem_q <= '0;
      src_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (!src_empty_i) begin
          w_q   <= head_i;
          ent_q <= ent_i;
          src_q <= src_o;
          st_q  <= ST_START;
        end
        ST_START: if (fire) st_q <= ST_SA;
        ST_SA: if (fire) begin
          if (ent_q.rd) begin
            bi_q <= ent_q.two_byte ? 2'd1 : 2'd0;
            st_q <= ST_RA;
          end else begin
            rem_q <= ent_q.cnt;
            bi_q  <= (ent_q.cnt >= 4'd3) ? 2'd2 : 2'(ent_q.cnt - 4'd1);
            st_q  <= (ent_q.cnt == 4'd0) ? ST_STOP : ST_PL;
          end
        end
        ST_PL: if (fire) begin
          rem_q <= rem_q - 4'd1;
          if (rem_q == 4'd1)   st_q <= ST_STOP;
          else if (bi_q == '0) st_q <= ST_FETCH;
          else                 bi_q <= bi_q - 2'd1;
        end
        ST_FETCH: if (!src_empty_i) begin
          w_q  <= head_i;
          bi_q <= (rem_q >= 4'd4) ? 2'd3 : 2'(rem_q - 4'd1);
          st_q <= ST_PL;
        end
        ST_RA: if (fire) begin
          if (bi_q == '0) st_q <= ST_RS;
          else            bi_q <= bi_q - 2'd1;
        end
        ST_RS:   if (fire) st_q <= ST_SA2;
        ST_SA2:  if (fire) st_q <= ST_STOP;
        ST_STOP: if (fire) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_cmd_seq.sv
`timescale 1ns/1ps
module frame_cmd_seq import fcs_pkg::*; #(
  parameter int FRAME_W = 4,
  parameter int DEPTH   = 8,
  parameter int PAGE_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_sync_i,
  input  logic               cmd_we_i,
  input  logic               cmd_rel_i,
  input  logic [FRAME_W-1:0] cmd_slot_i,
  input  logic [31:0]        cmd_data_i,
  input  logic               tbl_we_i,
  input  logic [PAGE_W-1:0]  tbl_page_i,
  input  logic [13:0]        tbl_ent_i,
  input  logic               tok_ready_i,
  output logic               tok_valid_o,
  output logic [1:0]         tok_type_o,
  output logic [7:0]         tok_data_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               overflow_o
);
  localparam int NSLOT    = 1 << FRAME_W;
  localparam int NQ       = NSLOT + 1;
  localparam int ASAP_IDX = NSLOT;
  localparam int QW       = $clog2(NQ);

  logic [FRAME_W-1:0] frame_q;
  logic               ovf_q;
  logic [31:0]        heads [NQ];
  logic [NQ-1:0]      empty, full, push, pop;
  logic [QW-1:0]      tgt, src;
  logic               tgt_ok, pop_en;
  logic [FRAME_W-1:0] rel_slot;
  page_ent_t          ent_rd;
  logic [31:0]        src_head;

  // relative target uses the frame value before a same-cycle sync
  assign rel_slot = frame_q + cmd_slot_i;

  always_comb begin
    tgt_ok = 1'b1;
    if (!cmd_rel_i)                            tgt = QW'(cmd_slot_i);
    else if (cmd_slot_i == '0)                 tgt = QW'(ASAP_IDX);
    else begin
      tgt = QW'(rel_slot);
      if (cmd_slot_i == FRAME_W'(NSLOT-1)) tgt_ok = 1'b0;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign push[g] = cmd_we_i && tgt_ok && (tgt == QW'(g));
    assign pop[g]  = pop_en && (src == QW'(g));
    fcs_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[g]),
      .pop_i   (pop[g]),
      .din_i   (cmd_data_i),
      .head_o  (heads[g]),
      .empty_o (empty[g]),
      .full_o  (full[g])
    );
  end

  assign src_head = heads[src];

  fcs_page_table #(.PAGE_W(PAGE_W)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_page_i),
    .wdata_i (page_ent_t'(tbl_ent_i)),
    .raddr_i (src_head[24 +: PAGE_W]),
    .rdata_o (ent_rd)
  );

  fcs_engine #(.FW(FRAME_W), .QW(QW), .ASAP_IDX(ASAP_IDX)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .asap_empty_i (empty[ASAP_IDX]),
    .frame_i      (frame_q),
    .head_i       (src_head),
    .src_empty_i  (empty[src]),
    .ent_i        (ent_rd),
    .tok_ready_i  (tok_ready_i),
    .src_o        (src),
    .pop_o        (pop_en),
    .tok_valid_o  (tok_valid_o),
    .tok_type_o   (tok_type_o),
    .tok_data_o   (tok_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (frame_sync_i) frame_q <= frame_q + 1'b1;
      if (cmd_we_i && tgt_ok && full[tgt]) ovf_q <= 1'b1;
    end
  end

  assign frame_o    = frame_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/frame_cmd_seq_chk.sv
`timescale 1ns/1ps
module frame_cmd_seq_chk #(
  parameter int FRAME_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_sync_i,
  input logic [FRAME_W-1:0] frame_o,
  input logic               overflow_o,
  input logic               tok_valid_o,
  input logic               tok_ready_i,
  input logic [1:0]         tok_type_o,
  input logic [7:0]         tok_data_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (frame_o == '0 && !overflow_o && !tok_valid_o);
    end
  end

  // R11
  tok_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_o && !tok_ready_i |=> tok_valid_o && $stable(tok_type_o) && $stable(tok_data_o));

  // R7
  frame_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_i |=> frame_o == FRAME_W'($past(frame_o) + 1'b1));

  // R7
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_sync_i |=> $stable(frame_o));

  // R10
  sticky_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
endmodule

bind frame_cmd_seq frame_cmd_seq_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_sync_i (frame_sync_i),
  .frame_o      (frame_o),
  .overflow_o   (overflow_o),
  .tok_valid_o  (tok_valid_o),
  .tok_ready_i  (tok_ready_i),
  .tok_type_o   (tok_type_o),
  .tok_data_o   (tok_data_o)
);

// File: tb/frame_cmd_seq_test.sv
`timescale 1ns/1ps
module frame_cmd_seq_test;
  localparam logic [1:0] T_ST = 2'd0, T_BY = 2'd1, T_RS = 2'd2, T_SP = 2'd3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic frame_sync_i = 1'b0;
  logic cmd_we_i = 1'b0;
  logic cmd_rel_i = 1'b0;
  logic [3:0] cmd_slot_i = '0;
  logic [31:0] cmd_data_i = '0;
  logic tbl_we_i = 1'b0;
  logic [3:0] tbl_page_i = '0;
  logic [13:0] tbl_ent_i = '0;
  logic tok_ready_i = 1'b1;
  logic tok_valid_o;
  logic [1:0] tok_type_o;
  logic [7:0] tok_data_o;
  logic [3:0] frame_o;
  logic overflow_o;

  int checks = 0;
  int errors = 0;
  int fr = 0;
  logic [9:0] got_q[$];
  logic [9:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  frame_cmd_seq uut (.*);

  always @(posedge clk_i)
    if (rst_ni && tok_valid_o && tok_ready_i) got_q.push_back({tok_type_o, tok_data_o});

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check_val(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_seq(string req);
    int bad = -1;
    checks++;
    if (got_q.size() != exp_q.size()) bad = 0;
    else foreach (exp_q[i]) if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: actual len %0d tok %0h expected len %0d tok %0h", req,
               got_q.size(), (got_q.size() > bad) ? got_q[bad] : 10'h3ff,
               exp_q.size(), (exp_q.size() > bad) ? exp_q[bad] : 10'h3ff);
    end
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic e(logic [1:0] t, logic [7:0] d);
    exp_q.push_back({t, d});
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(bit rel, logic [3:0] slot, logic [31:0] d, bit sync = 0);
    @(negedge clk_i);
    cmd_we_i = 1'b1; cmd_rel_i = rel; cmd_slot_i = slot; cmd_data_i = d;
    frame_sync_i = sync;
    if (sync) fr++;
    @(negedge clk_i);
    cmd_we_i = 1'b0; frame_sync_i = 1'b0;
  endtask

  task automatic sync_pulse();
    @(negedge clk_i);
    frame_sync_i = 1'b1; fr++;
    @(negedge clk_i);
    frame_sync_i = 1'b0;
  endtask

  task automatic tbl(logic [3:0] p, logic [13:0] ent);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_page_i = p; tbl_ent_i = ent;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  task automatic t_reset();
    check_val("R1 frame", int'(frame_o), 0);
    check_val("R1 overflow", int'(overflow_o), 0);
    check_val("R1 valid", int'(tok_valid_o), 0);
  endtask

  task automatic t_write3();  // R2
    got_q.delete();
    wr(1, 4'd0, 32'h01AABBCC);
    cyc(20);
    e(T_ST, 0); e(T_BY, 8'h48); e(T_BY, 8'hAA); e(T_BY, 8'hBB); e(T_BY, 8'hCC); e(T_SP, 0);
    check_seq("R2 write three bytes");
  endtask

  task automatic t_short();  // R3
    wr(1, 4'd0, 32'h02112233);
    cyc(20);
    e(T_ST, 0); e(T_BY, 8'h30); e(T_BY, 8'h22); e(T_BY, 8'h33); e(T_SP, 0);
    check_seq("R3 short count");
  endtask

  task automatic t_long();  // R4
    wr(1, 4'd0, 32'h03A1A2A3);
    wr(1, 4'd0, 32'h11223344);
    wr(1, 4'd0, 32'h55667788);
    cyc(30);
    e(T_ST, 0); e(T_BY, 8'h50);
    e(T_BY, 8'hA1); e(T_BY, 8'hA2); e(T_BY, 8'hA3);
    e(T_BY, 8'h11); e(T_BY, 8'h22); e(T_BY, 8'h33); e(T_BY, 8'h44);
    e(T_BY, 8'h77); e(T_BY, 8'h88); e(T_SP, 0);
    check_seq("R4 extra words");
  endtask

  task automatic t_read();  // R5
    wr(1, 4'd0, 32'h04A21234);
    cyc(20);
    e(T_ST, 0); e(T_BY, 8'hA2); e(T_BY, 8'h12); e(T_BY, 8'h34);
    e(T_RS, 0); e(T_BY, 8'hA3); e(T_SP, 0);
    check_seq("R5 read two-byte address");
    wr(1, 4'd0, 32'h05A31234);
    cyc(20);
    e(T_ST, 0); e(T_BY, 8'hA2); e(T_BY, 8'h34);
    e(T_RS, 0); e(T_BY, 8'hA3); e(T_SP, 0);
    check_seq("R5 read one-byte address");
  endtask

  task automatic t_abs();  // R6 R7
    wr(0, 4'(fr + 2), 32'h06000055);
    cyc(10);
    check_val("R6 held before frame", got_q.size(), 0);
    sync_pulse();
    cyc(10);
    check_val("R6 held one frame early", got_q.size(), 0);
    check_val("R7 frame step", int'(frame_o), fr % 16);
    sync_pulse();
    cyc(15);
    e(T_ST, 0); e(T_BY, 8'h20); e(T_BY, 8'h55); e(T_SP, 0);
    check_seq("R6 served on its frame");
  endtask

  task automatic t_rel();  // R8
    wr(1, 4'd3, 32'h06000066);
    sync_pulse(); sync_pulse();
    cyc(10);
    check_val("R8 offset 3 held", got_q.size(), 0);
    sync_pulse();
    cyc(15);
    e(T_ST, 0); e(T_BY, 8'h20); e(T_BY, 8'h66); e(T_SP, 0);
    check_seq("R8 offset 3 served");
  endtask

  task automatic t_prio();  // R9
    wr(0, 4'(fr + 1), 32'h060000A1);
    wr(1, 4'd0, 32'h060000B2, 1);
    cyc(20);
    e(T_ST, 0); e(T_BY, 8'h20); e(T_BY, 8'hB2); e(T_SP, 0);
    e(T_ST, 0); e(T_BY, 8'h20); e(T_BY, 8'hA1); e(T_SP, 0);
    check_seq("R9 ASAP first");
  endtask

  task automatic t_same_cycle();  // R8
    wr(1, 4'd1, 32'h060000C3, 1);
    cyc(15);
    e(T_ST, 0); e(T_BY, 8'h20); e(T_BY, 8'hC3); e(T_SP, 0);
    check_seq("R8 offset base is pre-sync frame");
  endtask

  task automatic t_off15();  // R8
    wr(1, 4'd15, 32'h060000D4);
    for (int i = 0; i < 16; i++) begin
      sync_pulse();
      cyc(2);
    end
    cyc(10);
    check_val("R8 offset 15 ignored", got_q.size(), 0);
    check_val("R8 offset 15 no overflow", int'(overflow_o), 0);
    check_val("R7 frame wrap", int'(frame_o), fr % 16);
  endtask

  task automatic t_ovf();  // R10
    logic [3:0] s;
    s = 4'(fr + 8);
    for (int i = 0; i < 9; i++) begin
      wr(0, s, 32'h06000000 | i);
      if (i == 7) check_val("R10 no flag at 8", int'(overflow_o), 0);
    end
    check_val("R10 flag on drop", int'(overflow_o), 1);
    for (int i = 0; i < 8; i++) sync_pulse();
    cyc(60);
    for (int i = 0; i < 8; i++) begin
      e(T_ST, 0); e(T_BY, 8'h20); e(T_BY, 8'(i)); e(T_SP, 0);
    end
    check_seq("R10 eight kept, ninth dropped");
    check_val("R10 flag sticky", int'(overflow_o), 1);
  endtask

  task automatic t_bp();  // R11
    wr(1, 4'd0, 32'h01AABBCC);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      tok_ready_i = (i % 3 == 2);
    end
    @(negedge clk_i);
    tok_ready_i = 1'b1;
    cyc(10);
    e(T_ST, 0); e(T_BY, 8'h48); e(T_BY, 8'hAA); e(T_BY, 8'hBB); e(T_BY, 8'hCC); e(T_SP, 0);
    check_seq("R11 backpressure keeps order");
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    tbl(4'd1, 14'h0349);
    tbl(4'd2, 14'h0230);
    tbl(4'd3, 14'h0950);
    tbl(4'd4, 14'h3000);
    tbl(4'd5, 14'h2000);
    tbl(4'd6, 14'h0120);
    cyc(2);
    check_val("R1 idle after setup", got_q.size(), 0);
    t_write3();
    t_short();
    t_long();
    t_read();
    t_abs();
    t_rel();
    t_prio();
    t_same_cycle();
    t_off15();
    t_ovf();
    t_bp();
    check_val("R7 final frame", int'(frame_o), fr % 16);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule